// File: doc/BRIEF.md
# Drawing-Command Packet Framer

This block sits at the front of a rasteriser. It takes a stream of 32-bit command words and finds where each drawing packet starts and ends. It reads the packet length from flag bits in the leading opcode byte. It then unpacks the packet into one flat primitive record: colours, vertex coordinates, texture coordinates, palette id, texture page and rectangle size. Each polygon, line, rectangle, dot or sprite produces one record. A polyline produces one record per segment, and the packet ends when a terminator word arrives.

Both edges use a valid/ready handshake. The framer holds exactly one finished record in an output register. While that record waits to be taken, the input side is stalled. An opcode the framer does not recognise is consumed as a single word and raises an error pulse. Framing then restarts on the following word.

Top module: `gpf_framer`

## Requirements
- R1: The first word of a packet carries the opcode in bits 31:24 and colour 0 (red 7:0, green 15:8, blue 23:16) in bits 23:0. Every record field the packet does not supply reads zero. rec_kind codes are 0 triangle, 1 quad, 2 line, 3 rectangle, 4 dot.
- R2: Polygon opcodes are 0x20–0x3C with bits 1:0 zero. Bit 2 selects textured, bit 3 selects four vertices, and bit 4 selects a colour word (bits 31:24 zero) before every vertex after the first. Packet lengths are 4, 7, 5, 9, 6, 9, 8 and 12 words for 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34, 0x38 and 0x3C.
- R3: A vertex word places Y in bits 31:16 and X in bits 15:0 and is reported unchanged in rec_xy. In textured forms, each vertex is followed by a word with U in 7:0 and V in 15:8. Its bits 31:16 give the palette id after vertex 0 and the texture page after vertex 1.
- R4: Opcode 0x40 is a line with two vertex words. Opcode 0x50 adds a colour word before the second vertex. Both give rec_kind 2.
- R5: Opcodes 0x48 (flat) and 0x58 (colour word before each later vertex) are polylines. Each vertex after the first emits a line record that pairs it with the previous vertex and colour. The word 0x55555555 ends the packet and emits nothing.
- R6: Opcode 0x60 is a rectangle: a corner word, then a size word (height 31:16, width 15:0). Opcode 0x64 inserts a palette/UV word before the size word.
- R7: Opcode 0x68 is a dot (one coordinate word, size 1x1). Opcodes 0x70/0x74 are 8x8 and 0x78/0x7C are 16x16. All of these carry no size word, and the textured forms (bit 2) add a palette/UV word.
- R8: Any other leading opcode is consumed as one word. err_opcode is high for exactly the cycle after that word is accepted, no record is produced, and the next word starts a new packet.
- R9: in_ready is low whenever rec_valid is high. A record that is not accepted stays unchanged until rec_ready.
- R10: After reset, rec_valid and err_opcode are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Framer can accept a word |
| in_data | input | 32 | Command word |
| rec_valid | output | 1 | Primitive record valid |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_kind | output | 3 | Primitive kind code |
| rec_tex | output | 1 | Record is textured |
| rec_shade | output | 1 | Record has per-vertex colours |
| rec_col | output | 4x24 | Colours per vertex |
| rec_xy | output | 4x32 | Vertex words, Y high and X low |
| rec_uv | output | 4x16 | Texture coordinates per vertex |
| rec_clut | output | 16 | Palette id |
| rec_tpage | output | 16 | Texture page |
| rec_size | output | 32 | Height 31:16, width 15:0 |
| err_opcode | output | 1 | Unsupported opcode pulse |

## Verification
A wrong word counter or phase state makes the framer lose its place in the stream. The record for the affected packet then has misplaced fields. Every later packet is also misread: its opcode is taken from the wrong word, which usually raises err_opcode or produces extra or missing records at the next comparison. A stale polyline slot shows as a wrong start vertex or colour in the very next segment record. The scoreboard compares every record field for field and also counts records, so a framing slip appears at the first record after it.

// File: rtl/gpf_pkg.sv
package gpf_pkg;
  localparam int VERTS = 4;
  localparam int COLW  = 24;
  localparam int XYW   = 32;
  localparam int UVW   = 16;
  localparam int IDW   = 16;

  typedef enum logic [2:0] {
    K_TRI  = 3'd0,
    K_QUAD = 3'd1,
    K_LINE = 3'd2,
    K_RECT = 3'd3,
    K_DOT  = 3'd4
  } prim_kind_e;

  typedef enum logic [1:0] {C_POLY, C_LINE, C_PLINE, C_RECT} cmd_class_e;

  typedef enum logic [2:0] {S_CMD, S_COL, S_VTX, S_UV, S_SIZE} seq_state_e;

  typedef struct packed {
    logic       ok;
    cmd_class_e cls;
    logic       tex;
    logic       quad;
    logic       shade;
    logic [1:0] rsize;   // 0 size word, 1 dot, 2 small square, 3 large square
  } op_info_t;

  typedef struct packed {
    prim_kind_e                   kind;
    logic                         tex;
    logic                         shade;
    logic [VERTS-1:0][COLW-1:0]   col;
    logic [VERTS-1:0][XYW-1:0]    xy;
    logic [VERTS-1:0][UVW-1:0]    uv;
    logic [IDW-1:0]               clut;
    logic [IDW-1:0]               tpage;
    logic [XYW-1:0]               size;
  } prim_rec_t;
endpackage

// File: rtl/gpf_opdec.sv
module gpf_opdec
  import gpf_pkg::*;
(
  input  logic [7:0] op,
  output op_info_t   info
);
  always_comb begin
    info = '0;
    case (op[7:5])
      3'b001: if (op[1:0] == 2'b00) begin
        info.ok    = 1'b1;
        info.cls   = C_POLY;
        info.tex   = op[2];
        info.quad  = op[3];
        info.shade = op[4];
      end
      3'b010: if (op[2:0] == 3'b000) begin
        info.ok    = 1'b1;
        info.cls   = op[3] ? C_PLINE : C_LINE;
        info.shade = op[4];
      end
      3'b011: if (op[1:0] == 2'b00 && !(op[4:3] == 2'b01 && op[2])) begin
        info.ok    = 1'b1;
        info.cls   = C_RECT;
        info.tex   = op[2];
        info.rsize = op[4:3];
      end
      default: info = '0;
    endcase
  end
endmodule

// File: rtl/gpf_seq.sv
module gpf_seq
  import gpf_pkg::*;
#(
  parameter logic [31:0] TERM_WORD  = 32'h5555_5555,
  parameter int          SMALL_SIDE = 8,
  parameter int          LARGE_SIDE = 16
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_fire,
  input  logic [31:0] in_data,
  output logic        emit,
  output prim_rec_t   rec_o,
  output logic        err_o
);
  localparam logic [15:0] SMALL = 16'(SMALL_SIDE);
  localparam logic [15:0] LARGE = 16'(LARGE_SIDE);

  seq_state_e state, nstate;
  logic [1:0] vidx, nvidx, last_idx;
  op_info_t   info_q, ninfo, dec;
  prim_rec_t  work, nwork, wnext;
  logic       bad, vtx_done, term_hit;

  gpf_opdec u_dec (.op(in_data[31:24]), .info(dec));

  function automatic prim_kind_e kind_of(input op_info_t i);
    case (i.cls)
      C_POLY:  kind_of = i.quad ? K_QUAD : K_TRI;
      C_RECT:  kind_of = (i.rsize == 2'd1) ? K_DOT : K_RECT;
      default: kind_of = K_LINE;
    endcase
  endfunction

  function automatic logic [31:0] implied_size(input op_info_t i);
    if (i.cls != C_RECT) implied_size = '0;
    else case (i.rsize)
      2'd1:    implied_size = {16'd1, 16'd1};
      2'd2:    implied_size = {SMALL, SMALL};
      2'd3:    implied_size = {LARGE, LARGE};
      default: implied_size = '0;
    endcase
  endfunction

  always_comb begin
    if (info_q.cls == C_LINE) last_idx = 2'd1;
    else                      last_idx = info_q.quad ? 2'd3 : 2'd2;
  end

  assign term_hit = (info_q.cls == C_PLINE) && (in_data == TERM_WORD);

  always_comb begin
    nstate   = state;
    nvidx    = vidx;
    ninfo    = info_q;
    nwork    = work;
    emit     = 1'b0;
    bad      = 1'b0;
    vtx_done = 1'b0;
    if (in_fire) begin
      case (state)
        S_CMD: begin
          if (!dec.ok) bad = 1'b1;
          else begin
            ninfo        = dec;
            nwork        = '0;
            nwork.kind   = kind_of(dec);
            nwork.tex    = dec.tex;
            nwork.shade  = dec.shade;
            nwork.col[0] = in_data[COLW-1:0];
            nwork.size   = implied_size(dec);
            nvidx        = 2'd0;
            nstate       = S_VTX;
          end
        end
        S_COL: begin
          if (term_hit) nstate = S_CMD;
          else begin
            nwork.col[vidx] = in_data[COLW-1:0];
            nstate          = S_VTX;
          end
        end
        S_VTX: begin
          if (term_hit) nstate = S_CMD;
          else begin
            nwork.xy[vidx] = in_data;
            case (info_q.cls)
              C_POLY: if (info_q.tex) nstate = S_UV; else vtx_done = 1'b1;
              C_LINE: vtx_done = 1'b1;
              C_PLINE: begin
                emit   = (vidx != 2'd0);
                nvidx  = 2'd1;
                nstate = info_q.shade ? S_COL : S_VTX;
              end
              default: begin
                if (info_q.rsize == 2'd0)  nstate = info_q.tex ? S_UV : S_SIZE;
                else if (info_q.tex)       nstate = S_UV;
                else begin
                  emit   = 1'b1;
                  nstate = S_CMD;
                end
              end
            endcase
          end
        end
        S_UV: begin
          nwork.uv[vidx] = in_data[UVW-1:0];
          if (vidx == 2'd0) nwork.clut  = in_data[31:16];
          if (vidx == 2'd1) nwork.tpage = in_data[31:16];
          if (info_q.cls == C_POLY)     vtx_done = 1'b1;
          else if (info_q.rsize == 2'd0) nstate = S_SIZE;
          else begin
            emit   = 1'b1;
            nstate = S_CMD;
          end
        end
        S_SIZE: begin
          nwork.size = in_data;
          emit       = 1'b1;
          nstate     = S_CMD;
        end
        default: nstate = S_CMD;
      endcase
      if (vtx_done) begin
        if (vidx == last_idx) begin
          emit   = 1'b1;
          nstate = S_CMD;
        end else begin
          nvidx  = vidx + 2'd1;
          nstate = info_q.shade ? S_COL : S_VTX;
        end
      end
    end
  end

  // A polyline keeps its newest vertex (and colour) as the start of the next segment.
  always_comb begin
    wnext = nwork;
    if (emit && info_q.cls == C_PLINE) begin
      wnext.xy[0] = nwork.xy[1];
      wnext.xy[1] = '0;
      if (info_q.shade) begin
        wnext.col[0] = nwork.col[1];
        wnext.col[1] = '0;
      end
    end
  end

  assign rec_o = nwork;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_CMD;
      vidx   <= 2'd0;
      info_q <= '0;
      work   <= '0;
      err_o  <= 1'b0;
    end else begin
      state  <= nstate;
      vidx   <= nvidx;
      info_q <= ninfo;
      work   <= wnext;
      err_o  <= bad;
    end
  end

  // R8: a rejected word leaves the sequencer waiting for a command
  a_r8_err_in_cmd: assert property (@(posedge clk) disable iff (rst)
    err_o |-> state == S_CMD);
  // R8: mid-packet states only follow a recognised opcode
  a_r8_valid_op: assert property (@(posedge clk) disable iff (rst)
    state != S_CMD |-> info_q.ok);
  // R1: a finished non-polyline packet returns to command framing
  a_r1_emit_returns: assert property (@(posedge clk) disable iff (rst)
    emit && info_q.cls != C_PLINE |=> state == S_CMD);
  // R2: three-vertex polygons never index a fourth vertex
  a_r2_tri_limit: assert property (@(posedge clk) disable iff (rst)
    state != S_CMD && info_q.cls == C_POLY && !info_q.quad |-> vidx <= 2'd2);
  // R5: polyline colour words only precede later vertices
  a_r5_pline_slot: assert property (@(posedge clk) disable iff (rst)
    state == S_COL && info_q.cls == C_PLINE |-> vidx == 2'd1);
endmodule

// File: rtl/gpf_outbuf.sv
module gpf_outbuf
  import gpf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  prim_rec_t rec_i,
  input  logic      rec_ready,
  output logic      rec_valid,
  output prim_rec_t rec_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_o     <= '0;
    end else if (load) begin
      rec_valid <= 1'b1;
      rec_o     <= rec_i;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

  // R9: a waiting record is never replaced
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    load |-> !rec_valid);
  // R9: an unaccepted record holds its contents
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_o));
endmodule

// File: rtl/gpf_framer.sv
module gpf_framer
  import gpf_pkg::*;
#(
  parameter logic [31:0] TERM_WORD  = 32'h5555_5555,
  parameter int          SMALL_SIDE = 8,
  parameter int          LARGE_SIDE = 16
)(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [31:0]                   in_data,
  output logic                          rec_valid,
  input  logic                          rec_ready,
  output logic [2:0]                    rec_kind,
  output logic                          rec_tex,
  output logic                          rec_shade,
  output logic [VERTS-1:0][COLW-1:0]    rec_col,
  output logic [VERTS-1:0][XYW-1:0]     rec_xy,
  output logic [VERTS-1:0][UVW-1:0]     rec_uv,
  output logic [IDW-1:0]                rec_clut,
  output logic [IDW-1:0]                rec_tpage,
  output logic [XYW-1:0]                rec_size,
  output logic                          err_opcode
);
  logic      in_fire, emit;
  prim_rec_t asm_rec, out_rec;

  assign in_ready = !rec_valid;
  assign in_fire  = in_valid && in_ready;

  gpf_seq #(
    .TERM_WORD(TERM_WORD), .SMALL_SIDE(SMALL_SIDE), .LARGE_SIDE(LARGE_SIDE)
  ) u_seq (
    .clk(clk), .rst(rst), .in_fire(in_fire), .in_data(in_data),
    .emit(emit), .rec_o(asm_rec), .err_o(err_opcode)
  );

  gpf_outbuf u_out (
    .clk(clk), .rst(rst), .load(emit), .rec_i(asm_rec),
    .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_o(out_rec)
  );

  assign rec_kind  = out_rec.kind;
  assign rec_tex   = out_rec.tex;
  assign rec_shade = out_rec.shade;
  assign rec_col   = out_rec.col;
  assign rec_xy    = out_rec.xy;
  assign rec_uv    = out_rec.uv;
  assign rec_clut  = out_rec.clut;
  assign rec_tpage = out_rec.tpage;
  assign rec_size  = out_rec.size;
endmodule

// File: tb/gpf_framer_bench.sv
module gpf_framer_bench;
  import gpf_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TERM = 32'h5555_5555;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic rec_valid, rec_ready = 1'b1;
  logic [2:0] rec_kind;
  logic rec_tex, rec_shade, err_opcode;
  logic [VERTS-1:0][COLW-1:0] rec_col;
  logic [VERTS-1:0][XYW-1:0]  rec_xy;
  logic [VERTS-1:0][UVW-1:0]  rec_uv;
  logic [IDW-1:0] rec_clut, rec_tpage;
  logic [XYW-1:0] rec_size;

  int checks = 0, errors = 0, cyc = 0, words = 0;
  bit bp = 1'b0, done = 1'b0;
  prim_rec_t exp_q[$];
  string     tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpf_framer u_gpf_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_kind(rec_kind), .rec_tex(rec_tex),
    .rec_shade(rec_shade), .rec_col(rec_col), .rec_xy(rec_xy), .rec_uv(rec_uv),
    .rec_clut(rec_clut), .rec_tpage(rec_tpage), .rec_size(rec_size), .err_opcode(err_opcode)
  );

  task automatic check(input string tag, input logic [359:0] a, input logic [359:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic logic [23:0] cf(int s, int k); return 24'((s * 37 + k * 101) * 65793); endfunction
  function automatic logic [31:0] vf(int s, int k); return {16'(s * 13 + k * 5 + 1), 16'(s * 7 + k * 3 + 2)}; endfunction
  function automatic logic [15:0] uvf(int s, int k); return {8'(s + k * 9), 8'(s * 3 + k)}; endfunction

  // Driver: caller stands at a falling edge; returns at the falling edge after acceptance.
  task automatic put(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    words++;
  endtask

  task automatic expect_rec(input prim_rec_t e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send_poly(input logic [7:0] op, input int s);
    prim_rec_t e;
    int nv, want;
    logic tex, sh;
    tex = op[2]; sh = op[4]; nv = op[3] ? 4 : 3;
    e = '0;
    e.kind = op[3] ? K_QUAD : K_TRI; e.tex = tex; e.shade = sh; e.col[0] = cf(s, 0);
    for (int k = 0; k < nv; k++) begin
      if (sh && k > 0) e.col[k] = cf(s, k);
      e.xy[k] = vf(s, k);
      if (tex) e.uv[k] = uvf(s, k);
    end
    if (tex) begin e.clut = 16'(s * 11 + 16'h4000); e.tpage = 16'(s * 5 + 16'h0200); end
    expect_rec(e, tex ? "R3" : "R2");
    words = 0;
    put({op, cf(s, 0)});
    for (int k = 0; k < nv; k++) begin
      if (sh && k > 0) put({8'h00, cf(s, k)});
      put(vf(s, k));
      if (tex) put({(k == 0) ? e.clut : (k == 1) ? e.tpage : 16'h0, uvf(s, k)});
    end
    case (op)
      8'h20: want = 4;  8'h24: want = 7;  8'h28: want = 5;  8'h2C: want = 9;
      8'h30: want = 6;  8'h34: want = 9;  8'h38: want = 8;  default: want = 12;
    endcase
    check("R2 packet length", 360'(words), 360'(want));
  endtask

  task automatic send_line(input logic [7:0] op, input int s);
    prim_rec_t e;
    e = '0; e.kind = K_LINE; e.shade = op[4];
    e.col[0] = cf(s, 0); e.xy[0] = vf(s, 0); e.xy[1] = vf(s, 1);
    if (op[4]) e.col[1] = cf(s, 1);
    expect_rec(e, "R4");
    put({op, cf(s, 0)}); put(vf(s, 0));
    if (op[4]) put({8'h00, cf(s, 1)});
    put(vf(s, 1));
  endtask

  task automatic send_pline(input logic [7:0] op, input int s, input int n);
    prim_rec_t e;
    for (int k = 1; k < n; k++) begin
      e = '0; e.kind = K_LINE; e.shade = op[4];
      e.col[0] = op[4] ? cf(s, k - 1) : cf(s, 0);
      if (op[4]) e.col[1] = cf(s, k);
      e.xy[0] = vf(s, k - 1); e.xy[1] = vf(s, k);
      expect_rec(e, "R5");
    end
    put({op, cf(s, 0)}); put(vf(s, 0));
    for (int k = 1; k < n; k++) begin
      if (op[4]) put({8'h00, cf(s, k)});
      put(vf(s, k));
    end
    put(TERM);
  endtask

  task automatic send_rect(input logic [7:0] op, input int s);
    prim_rec_t e;
    e = '0; e.kind = (op == 8'h68) ? K_DOT : K_RECT; e.tex = op[2];
    e.col[0] = cf(s, 0); e.xy[0] = vf(s, 0);
    if (op[2]) begin e.uv[0] = uvf(s, 0); e.clut = 16'(s * 11 + 16'h4000); end
    case (op)
      8'h60, 8'h64: e.size = vf(s, 7);
      8'h68:        e.size = {16'd1, 16'd1};
      8'h70, 8'h74: e.size = {16'd8, 16'd8};
      default:      e.size = {16'd16, 16'd16};
    endcase
    expect_rec(e, (op[6:3] == 4'b1100) ? "R6" : "R7");
    put({op, cf(s, 0)}); put(vf(s, 0));
    if (op[2]) put({e.clut, uvf(s, 0)});
    if (op == 8'h60 || op == 8'h64) put(vf(s, 7));
  endtask

  task automatic send_bad(input logic [7:0] op);
    put({op, 24'hABCDEF});
    check("R8 error pulse", 360'(err_opcode), 360'(1));
    @(negedge clk);
    check("R8 error one cycle", 360'(err_opcode), 360'(0));
    check("R8 no record", 360'(rec_valid), 360'(0));
  endtask

  // Consumer back-pressure, changed only at rising edges.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rec_ready <= !bp || (cyc % 3 == 0);
  end

  // Monitor / scoreboard.
  prim_rec_t act, held;
  bit hold_pend = 1'b0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      act = '0;
      act.kind = prim_kind_e'(rec_kind); act.tex = rec_tex; act.shade = rec_shade;
      act.col = rec_col; act.xy = rec_xy; act.uv = rec_uv;
      act.clut = rec_clut; act.tpage = rec_tpage; act.size = rec_size;
      if (hold_pend) begin
        check("R9 held valid", 360'(rec_valid), 360'(1));
        check("R9 held record", 360'(act), 360'(held));
      end
      if (rec_valid) check("R9 input stalled", 360'(in_ready), 360'(0));
      if (rec_valid && rec_ready) begin
        if (exp_q.size() == 0) check("R9 unexpected record", 360'(act), 360'(0));
        else begin
          prim_rec_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " record"}, 360'(act), 360'(e));
        end
      end
      hold_pend = rec_valid && !rec_ready;
      held = act;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 rec_valid after reset", 360'(rec_valid), 360'(0));
    check("R10 in_ready after reset", 360'(in_ready), 360'(1));
    check("R10 err after reset", 360'(err_opcode), 360'(0));
    for (int pass = 0; pass < 2; pass++) begin
      bp = (pass == 1);
      for (int i = 0; i < 8; i++) send_poly(8'(8'h20 + 4 * i), 3 + i + pass * 20);
      send_bad(8'h21);
      send_line(8'h40, 11 + pass);
      send_line(8'h50, 12 + pass);
      send_bad(8'h80);
      send_pline(8'h48, 14 + pass, 4);
      send_pline(8'h58, 15 + pass, 3);
      send_pline(8'h58, 16 + pass, 1);
      send_pline(8'h48, 17 + pass, 2);
      send_bad(8'h6C);
      send_rect(8'h60, 18 + pass);
      send_rect(8'h64, 19 + pass);
      send_rect(8'h68, 20 + pass);
      send_rect(8'h70, 21 + pass);
      send_rect(8'h74, 22 + pass);
      send_rect(8'h78, 23 + pass);
      send_rect(8'h7C, 24 + pass);
      send_bad(8'h1F);
      send_poly(8'h3C, 40 + pass);
    end
    for (int w = 0; w < 200 && (exp_q.size() != 0 || rec_valid); w++) @(negedge clk);
    check("R1 all records delivered", 360'(exp_q.size()), 360'(0));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule